// File: doc/BRIEF.md
# Match-Compare Operating-System Timer

This block is a bus-mapped timer built around one free-running 32-bit up counter and four 32-bit compare channels. Each time the counter moves to a new value, whether by a tick or by a software load, the new value is compared against every compare register. A hit on a channel whose interrupt is enabled latches a sticky status bit and drives that channel's level interrupt. Software clears the status with a write-one-to-clear access.

The last compare channel also serves as a watchdog. Software arms it by writing a 1 to bit 0 of the watchdog register. A hit on that channel while armed emits a one-cycle reset request, and the watchdog register returns to zero. The watchdog runs as a three-state machine: `WD_IDLE` (disarmed), `WD_ARMED` and `WD_FIRE` (pulse cycle). It has these transitions:
- `ARM`: IDLE to ARMED when bit 0 is written as 1.
- `DISARM`: ARMED to IDLE when bit 0 is written as 0.
- `TRIP`: ARMED to FIRE when channel 3 hits.
- `REARM`: FIRE to ARMED when bit 0 is written as 1 during the pulse cycle.
- `RETIRE`: FIRE to IDLE otherwise.

The `tick_i` input paces the counter. Register reads return data one cycle after the access, qualified by `bus_rvalid_o`.

Top module: `ost_top`

## Requirements
- R1: After reset, every register reads 0, `irq_o` is 0 and `rst_req_o` is low.
- R2: At a clock edge with `tick_i` high and no counter write, the counter (offset 0x10) increments by 1, wrapping from 0xFFFFFFFF to 0. With `tick_i` low and no counter write, the counter holds its value.
- R3: A write to offset 0x10 loads the written value at that edge. A tick in the same cycle is ignored.
- R4: When the counter takes a new value (by tick or by load) equal to compare register i (offsets 0x00, 0x04, 0x08, 0x0C for i = 0..3), and bit i of the enable register (0x1C) is 1, then status bit i (0x14, bit i) and `irq_o[i]` go high at that same edge. Matching uses all 32 bits, so a hit on value 0 occurs again after a wrap.
- R5: A hit on a channel whose enable bit is 0 leaves both the status bit and the interrupt line low.
- R6: Writing 0x14 clears each status bit written as 1 and leaves bits written as 0 unchanged. If a clear and a new hit on the same bit fall in one cycle, the bit stays set. Interrupt lines follow the status bits.
- R7: The enable register keeps bits 11:0 of a write. Bits 31:12 read back as 0.
- R8: When channel 3 hits while bit 0 of the watchdog register (0x18) is 1, `rst_req_o` is high for exactly one cycle, starting at the hit edge, and 0x18 reads 0 afterwards. This does not depend on the enable bits. With bit 0 clear, no pulse occurs.
- R9: Reads of the compare registers and of 0x18 return the stored values.
- R10: An access to an unmapped offset (anything other than 0x00–0x1C on a 4-byte boundary) has no effect, reads as 0, and raises `bus_err_o` for the one cycle following the access.
- R11: Writing a compare register with the counter's current value causes no hit; only a later counter update can match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Counter advance enable |
| bus_sel_i | input | 1 | Register access strobe |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | ADDR_W (8) | Byte offset |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid with bus_rvalid_o |
| bus_rvalid_o | output | 1 | Read data valid, one cycle after a read |
| bus_err_o | output | 1 | Unmapped access, one cycle after it |
| irq_o | output | 4 | Per-channel level interrupts |
| rst_req_o | output | 1 | Watchdog reset request pulse |

## Verification
Two functions can collide in one cycle: a software write-one-to-clear of a status bit, and a counter step that produces a fresh hit on that same channel. The bench provokes this by loading the counter one below the compare value and then issuing the status clear with `tick_i` held high in the same cycle. The bit must read back as 1 and its interrupt must stay high. The second collision is a counter load and a tick in the same cycle, which is judged by reading back exactly the loaded value.

// File: rtl/ost_pkg.sv
package ost_pkg;

    localparam int NUM_CH  = 4;
    localparam int DATA_W  = 32;
    localparam int IEN_W   = 12;
    localparam int WD_CH   = NUM_CH - 1;

    localparam logic [7:0] OFF_CNT  = 8'h10;
    localparam logic [7:0] OFF_STAT = 8'h14;
    localparam logic [7:0] OFF_WDOG = 8'h18;
    localparam logic [7:0] OFF_IEN  = 8'h1C;

    typedef enum logic [1:0] {
        WD_IDLE  = 2'd0,
        WD_ARMED = 2'd1,
        WD_FIRE  = 2'd2
    } wd_state_e;

    function automatic logic [7:0] match_off(input int idx);
        return 8'(idx * 4);
    endfunction

endpackage

// File: rtl/ost_counter.sv
module ost_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             tick_i,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic [CNT_W-1:0] nxt_o,
    output logic             upd_o
);

    logic [CNT_W-1:0] cnt_q;

    // load takes precedence over a tick in the same cycle
    always_comb begin
        upd_o = load_i | tick_i;
        nxt_o = load_i ? load_val_i : cnt_q + CNT_W'(1);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else if (upd_o) begin
            cnt_q <= nxt_o;
        end
    end

    assign cnt_o = cnt_q;

endmodule

// File: rtl/ost_match_chan.sv
module ost_match_chan #(
    parameter int CNT_W = 32
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             wr_i,
    input  logic [CNT_W-1:0] wdata_i,
    input  logic             cnt_upd_i,
    input  logic [CNT_W-1:0] cnt_nxt_i,
    output logic [CNT_W-1:0] match_o,
    output logic             hit_o
);

    logic [CNT_W-1:0] match_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            match_q <= '0;
        end else if (wr_i) begin
            match_q <= wdata_i;
        end
    end

    // a hit is an event on the counter moving into the compare value
    assign hit_o   = cnt_upd_i && (cnt_nxt_i == match_q);
    assign match_o = match_q;

endmodule

// File: rtl/ost_watchdog.sv
module ost_watchdog
    import ost_pkg::*;
#(
    parameter int REG_W = 32
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             wr_i,
    input  logic [REG_W-1:0] wdata_i,
    input  logic             hit_i,
    output logic [REG_W-1:0] reg_o,
    output logic             rst_req_o
);

    wd_state_e        state_q, state_d;
    logic [REG_W-1:0] reg_q;
    logic             trip;

    assign trip = (state_q == WD_ARMED) && hit_i;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WD_IDLE: begin
                if (wr_i && wdata_i[0]) state_d = WD_ARMED;           // ARM
            end
            WD_ARMED: begin
                if (hit_i)                     state_d = WD_FIRE;     // TRIP
                else if (wr_i && !wdata_i[0])  state_d = WD_IDLE;     // DISARM
            end
            WD_FIRE: begin
                if (wr_i && wdata_i[0]) state_d = WD_ARMED;           // REARM
                else                    state_d = WD_IDLE;            // RETIRE
            end
            default: state_d = WD_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= WD_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // register content: a trip wins over a concurrent write
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            reg_q <= '0;
        end else if (trip) begin
            reg_q <= '0;
        end else if (wr_i) begin
            reg_q <= wdata_i;
        end
    end

    always_comb begin
        rst_req_o = (state_q == WD_FIRE);
        reg_o     = reg_q;
    end

endmodule

// File: rtl/ost_top.sv
module ost_top
    import ost_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int CNT_W  = 32
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              tick_i,
    input  logic              bus_sel_i,
    input  logic              bus_wr_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    output logic [DATA_W-1:0] bus_rdata_o,
    output logic              bus_rvalid_o,
    output logic              bus_err_o,
    output logic [NUM_CH-1:0] irq_o,
    output logic              rst_req_o
);

    logic              wr_acc, rd_acc;
    logic [NUM_CH-1:0] sel_match;
    logic              sel_cnt, sel_stat, sel_wdog, sel_ien, mapped;
    logic              cnt_load, st_wr, wd_wr;

    logic [CNT_W-1:0]  cnt_q, cnt_nxt;
    logic              cnt_upd;
    logic [CNT_W-1:0]  match_v [NUM_CH];
    logic [NUM_CH-1:0] hit;
    logic [NUM_CH-1:0] status_q;
    logic [IEN_W-1:0]  ien_q;
    logic [DATA_W-1:0] wd_q;
    logic [DATA_W-1:0] rd_mux;

    // ---------------- address decode ----------------
    assign wr_acc = bus_sel_i &  bus_wr_i;
    assign rd_acc = bus_sel_i & ~bus_wr_i;

    generate
        for (genvar i = 0; i < NUM_CH; i++) begin : g_dec
            assign sel_match[i] = (bus_addr_i == ADDR_W'(match_off(i)));
        end
    endgenerate

    assign sel_cnt  = (bus_addr_i == ADDR_W'(OFF_CNT));
    assign sel_stat = (bus_addr_i == ADDR_W'(OFF_STAT));
    assign sel_wdog = (bus_addr_i == ADDR_W'(OFF_WDOG));
    assign sel_ien  = (bus_addr_i == ADDR_W'(OFF_IEN));
    assign mapped   = (|sel_match) | sel_cnt | sel_stat | sel_wdog | sel_ien;

    assign cnt_load = wr_acc & sel_cnt;
    assign st_wr    = wr_acc & sel_stat;
    assign wd_wr    = wr_acc & sel_wdog;

    // ---------------- counter ----------------
    ost_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .tick_i     (tick_i),
        .load_i     (cnt_load),
        .load_val_i (bus_wdata_i[CNT_W-1:0]),
        .cnt_o      (cnt_q),
        .nxt_o      (cnt_nxt),
        .upd_o      (cnt_upd)
    );

    // ---------------- compare channels and status ----------------
    generate
        for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
            ost_match_chan #(.CNT_W(CNT_W)) u_ch (
                .clk_i     (clk_i),
                .rst_ni    (rst_ni),
                .wr_i      (wr_acc & sel_match[i]),
                .wdata_i   (bus_wdata_i[CNT_W-1:0]),
                .cnt_upd_i (cnt_upd),
                .cnt_nxt_i (cnt_nxt),
                .match_o   (match_v[i]),
                .hit_o     (hit[i])
            );

            // a new enabled hit outranks a clear in the same cycle
            always_ff @(posedge clk_i or negedge rst_ni) begin
                if (!rst_ni) begin
                    status_q[i] <= 1'b0;
                end else if (hit[i] && ien_q[i]) begin
                    status_q[i] <= 1'b1;
                end else if (st_wr && bus_wdata_i[i]) begin
                    status_q[i] <= 1'b0;
                end
            end
        end
    endgenerate

    assign irq_o = status_q;

    // ---------------- interrupt enable ----------------
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            ien_q <= '0;
        end else if (wr_acc && sel_ien) begin
            ien_q <= bus_wdata_i[IEN_W-1:0];
        end
    end

    // ---------------- watchdog ----------------
    ost_watchdog #(.REG_W(DATA_W)) u_wd (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .wr_i      (wd_wr),
        .wdata_i   (bus_wdata_i),
        .hit_i     (hit[WD_CH]),
        .reg_o     (wd_q),
        .rst_req_o (rst_req_o)
    );

    // ---------------- read path ----------------
    always_comb begin
        rd_mux = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (sel_match[i]) rd_mux = DATA_W'(match_v[i]);
        end
        if (sel_cnt)  rd_mux = DATA_W'(cnt_q);
        if (sel_stat) rd_mux = DATA_W'(status_q);
        if (sel_wdog) rd_mux = wd_q;
        if (sel_ien)  rd_mux = DATA_W'(ien_q);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            bus_rdata_o  <= '0;
            bus_rvalid_o <= 1'b0;
            bus_err_o    <= 1'b0;
        end else begin
            bus_rvalid_o <= rd_acc;
            bus_err_o    <= bus_sel_i & ~mapped;
            if (rd_acc) bus_rdata_o <= rd_mux;
        end
    end

endmodule

// File: rtl/ost_chk.sv
module ost_chk
    import ost_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              tick_i,
    input logic              bus_sel_i,
    input logic [DATA_W-1:0] bus_wdata_i,
    input logic              cnt_load,
    input logic              st_wr,
    input logic [CNT_W-1:0]  cnt_q,
    input logic [IEN_W-1:0]  ien_q,
    input logic [NUM_CH-1:0] irq_o,
    input logic [DATA_W-1:0] wd_q,
    input logic              rst_req_o,
    input logic              bus_err_o
);

    assert_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!tick_i && !cnt_load) |=> $stable(cnt_q));

    assert_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tick_i && !cnt_load) |=> (cnt_q == $past(cnt_q) + CNT_W'(1)));

    assert_load_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cnt_load |=> (cnt_q == $past(bus_wdata_i[CNT_W-1:0])));

    assert_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rst_req_o |=> !rst_req_o);

    assert_wdclr_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rst_req_o |-> (wd_q == '0));

    assert_err_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        bus_err_o |-> $past(bus_sel_i));

    generate
        for (genvar i = 0; i < NUM_CH; i++) begin : g_irq
            assert_en_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
                $rose(irq_o[i]) |-> $past(ien_q[i]));

            assert_clr_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
                $fell(irq_o[i]) |-> $past(st_wr && bus_wdata_i[i]));
        end
    endgenerate

endmodule

bind ost_top ost_chk #(.CNT_W(CNT_W)) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tick_i      (tick_i),
    .bus_sel_i   (bus_sel_i),
    .bus_wdata_i (bus_wdata_i),
    .cnt_load    (cnt_load),
    .st_wr       (st_wr),
    .cnt_q       (cnt_q),
    .ien_q       (ien_q),
    .irq_o       (irq_o),
    .wd_q        (wd_q),
    .rst_req_o   (rst_req_o),
    .bus_err_o   (bus_err_o)
);

// File: tb/test_ost_top.sv
module test_ost_top;

    localparam int CLK_PERIOD = 10;

    localparam logic [7:0] A_M0 = 8'h00, A_M1 = 8'h04, A_M2 = 8'h08, A_M3 = 8'h0C;
    localparam logic [7:0] A_CNT = 8'h10, A_ST = 8'h14, A_WD = 8'h18, A_IEN = 8'h1C;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        sel = 1'b0;
    logic        wr = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        rvalid, berr, rreq;
    logic [3:0]  irq;

    int checks = 0;
    int errors = 0;
    int pulses = 0;
    bit done   = 1'b0;

    typedef struct {
        logic [31:0] exp;
        string       tag;
    } item_t;
    item_t sb_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    ost_top i_ost_top (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .tick_i       (tick),
        .bus_sel_i    (sel),
        .bus_wr_i     (wr),
        .bus_addr_i   (addr),
        .bus_wdata_i  (wdata),
        .bus_rdata_o  (rdata),
        .bus_rvalid_o (rvalid),
        .bus_err_o    (berr),
        .irq_o        (irq),
        .rst_req_o    (rreq)
    );

    task automatic check(input bit ok, input string tag,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor: pops the scoreboard as read data emerges
    always @(negedge clk) begin
        item_t it;
        if (rst_n && rvalid) begin
            if (sb_q.size() == 0) begin
                check(1'b0, "unexpected read data", rdata, 32'h0);
            end else begin
                it = sb_q.pop_front();
                check(rdata === it.exp, it.tag, rdata, it.exp);
            end
        end
        if (rst_n && rreq) pulses++;
    end

    task automatic acc(input bit w, input logic [7:0] a,
                       input logic [31:0] d, input bit t);
        @(negedge clk);
        sel = 1'b1; wr = w; addr = a; wdata = d; tick = t;
        @(negedge clk);
        sel = 1'b0; wr = 1'b0; tick = 1'b0;
    endtask

    task automatic wr_reg(input logic [7:0] a, input logic [31:0] d);
        acc(1'b1, a, d, 1'b0);
    endtask

    task automatic rd_reg(input logic [7:0] a, input logic [31:0] e, input string tag);
        item_t it;
        it.exp = e;
        it.tag = tag;
        sb_q.push_back(it);
        acc(1'b0, a, 32'h0, 1'b0);
    endtask

    task automatic ticks(input int n);
        @(negedge clk);
        tick = 1'b1;
        repeat (n) @(negedge clk);
        tick = 1'b0;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            check(1'b0, "watchdog expired", 32'h0, 32'h1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : stim
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd_reg(A_M0, 0, "R1 match0");
        rd_reg(A_M1, 0, "R1 match1");
        rd_reg(A_M2, 0, "R1 match2");
        rd_reg(A_M3, 0, "R1 match3");
        rd_reg(A_CNT, 0, "R1 counter");
        rd_reg(A_ST, 0, "R1 status");
        rd_reg(A_WD, 0, "R1 watchdog");
        rd_reg(A_IEN, 0, "R1 enable");
        check(irq === 4'h0, "R1 irq", 32'(irq), 0);
        check(rreq === 1'b0, "R1 rst_req", 32'(rreq), 0);

        // R2 count and hold
        ticks(5);
        rd_reg(A_CNT, 5, "R2 count after 5 ticks");
        repeat (3) @(negedge clk);
        rd_reg(A_CNT, 5, "R2 hold without tick");

        // R3 load, load beats tick
        wr_reg(A_CNT, 100);
        rd_reg(A_CNT, 100, "R3 load");
        acc(1'b1, A_CNT, 200, 1'b1);
        rd_reg(A_CNT, 200, "R3 load with tick");

        // R7 enable width
        wr_reg(A_IEN, 32'hFFFF_F00F);
        rd_reg(A_IEN, 32'h0000_000F, "R7 enable masked");
        wr_reg(A_IEN, 32'h1);

        // R4 match on tick
        wr_reg(A_M0, 203);
        ticks(2);
        check(irq === 4'h0, "R4 no irq before match", 32'(irq), 0);
        ticks(1);
        check(irq === 4'h1, "R4 irq0 on match", 32'(irq), 1);
        rd_reg(A_ST, 1, "R4 status0");
        rd_reg(A_CNT, 203, "R4 count");

        // R5 disabled channel
        wr_reg(A_M1, 205);
        ticks(2);
        check(irq[1] === 1'b0, "R5 irq1 stays low", 32'(irq[1]), 0);
        rd_reg(A_ST, 1, "R5 status1 not set");

        // R6 write-one-to-clear
        wr_reg(A_ST, 32'h2);
        rd_reg(A_ST, 1, "R6 zero bit untouched");
        wr_reg(A_ST, 32'h1);
        rd_reg(A_ST, 0, "R6 cleared");
        check(irq === 4'h0, "R6 irq dropped", 32'(irq), 0);

        // R4 match on load
        wr_reg(A_M0, 210);
        wr_reg(A_CNT, 210);
        check(irq[0] === 1'b1, "R4 match on load", 32'(irq[0]), 1);
        // R6 clear and new hit in one cycle
        wr_reg(A_CNT, 209);
        acc(1'b1, A_ST, 32'h1, 1'b1);
        rd_reg(A_ST, 1, "R6 set wins over clear");
        check(irq[0] === 1'b1, "R6 irq0 kept", 32'(irq[0]), 1);

        // R4 wrap
        wr_reg(A_ST, 32'h1);
        wr_reg(A_IEN, 32'h5);
        wr_reg(A_M2, 0);
        wr_reg(A_CNT, 32'hFFFF_FFFE);
        ticks(1);
        check(irq[2] === 1'b0, "R4 no hit before wrap", 32'(irq[2]), 0);
        ticks(1);
        check(irq[2] === 1'b1, "R4 hit at wrap", 32'(irq[2]), 1);
        rd_reg(A_CNT, 0, "R2 wrap to zero");

        // R11 compare written with current count
        wr_reg(A_ST, 32'hF);
        wr_reg(A_M2, 0);
        check(irq === 4'h0, "R11 no hit on compare write", 32'(irq), 0);
        rd_reg(A_ST, 0, "R11 status clear");

        // R8 watchdog trip
        wr_reg(A_M3, 50);
        wr_reg(A_CNT, 45);
        wr_reg(A_WD, 32'h1);
        rd_reg(A_WD, 1, "R9 watchdog readback");
        ticks(5);
        check(rreq === 1'b1, "R8 reset request", 32'(rreq), 1);
        @(negedge clk);
        check(rreq === 1'b0, "R8 single cycle", 32'(rreq), 0);
        rd_reg(A_WD, 0, "R8 watchdog cleared");
        rd_reg(A_ST, 0, "R8 status3 stays low when disabled");
        check(pulses == 1, "R8 pulse count", 32'(pulses), 1);

        // R8 disarmed: no pulse
        wr_reg(A_CNT, 45);
        ticks(5);
        @(negedge clk);
        check(pulses == 1, "R8 no pulse when disarmed", 32'(pulses), 1);

        // R9 compare readback
        rd_reg(A_M0, 210, "R9 match0");
        rd_reg(A_M1, 205, "R9 match1");
        rd_reg(A_M2, 0, "R9 match2");
        rd_reg(A_M3, 50, "R9 match3");

        // R10 unmapped
        rd_reg(8'h24, 0, "R10 unmapped read");
        check(berr === 1'b1, "R10 error on read", 32'(berr), 1);
        @(negedge clk);
        check(berr === 1'b0, "R10 error one cycle", 32'(berr), 0);
        wr_reg(8'h22, 32'hFFFF_FFFF);
        check(berr === 1'b1, "R10 error on write", 32'(berr), 1);
        rd_reg(A_ST, 0, "R10 status untouched");
        rd_reg(A_IEN, 5, "R10 enable untouched");

        repeat (3) @(negedge clk);
        check(sb_q.size() == 0, "scoreboard drained", 32'(sb_q.size()), 0);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule